// File: doc/BRIEF.md
# Power-Good Strap Capture and CPU Frequency Decode

This block takes a snapshot of the board strap inputs the first time an active-low power-good strobe is qualified low. The straps are three frequency-select bits and one table-select bit. From that snapshot it derives an encoded CPU clock frequency. Two selection tables are supported: one that uses all three select bits, and one that looks only at the two low bits. A flag marks codes that are reserved or unassigned.

The capture happens only once. After it, the strap inputs are never looked at again until the next reset. The strobe pin then takes on a new meaning as a live, active-high power-down request. The strobe first passes through a synchroniser. It must then be seen low on consecutive synchronised samples before the capture is accepted, so a short glitch cannot trigger a capture.

Top module: `strap_capture_top`

## Requirements
- R1: While reset is applied and afterwards until a capture, `captured` is 0, `latchedSel` is 000, `latchedTable` is 0 (the pull-down default), `cpuFreq` is 0 (the 100 MHz code), and `reservedCode` and `powerDown` are 0.
- R2: The strobe may go low before a rising clock edge k and stay low. Then `captured` becomes 1 after edge k+3 and not earlier. `latchedSel` and `latchedTable` hold the values that `selBits` and `tableSel` had before that edge.
- R3: A strobe low that lasts only one clock cycle causes no capture.
- R4: After a capture, strobe activity and changes on `selBits` and `tableSel` leave `captured`, `latchedSel`, `latchedTable`, `cpuFreq` and `reservedCode` unchanged until reset.
- R5: With latched table 0, the code {C,B,A} = {selBits[2],selBits[1],selBits[0]} decodes as follows: 101 gives `cpuFreq`=0 (100 MHz), 001 gives 1 (133 MHz), 010 gives 2 (200 MHz) and 000 gives 3 (266 MHz).
- R6: With latched table 1, only {B,A} is decoded: 00 gives 0, 01 gives 1 and 10 gives 2. `selBits[2]` has no effect.
- R7: A reserved or unassigned code sets `reservedCode` to 1 and sets `cpuFreq` to 0. These codes are 111, 011, 100 and 110 in table 0, and {B,A}=11 in table 1.
- R8: After a capture, `powerDown` follows the strobe level, active high, three clock edges after the strobe changes.
- R9: `powerDown` stays 0 before a capture, whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrStrobe | input | 1 | Power-good strobe (active low) before capture; power-down request (active high) after it |
| selBits | input | 3 | Frequency-select straps: bit2=C, bit1=B, bit0=A |
| tableSel | input | 1 | Table-select strap: 0 = three-bit table, 1 = two-bit table |
| captured | output | 1 | The one-shot capture has happened |
| latchedSel | output | 3 | Captured frequency-select straps |
| latchedTable | output | 1 | Captured table-select strap |
| cpuFreq | output | 2 | CPU frequency code: 0=100, 1=133, 2=200, 3=266 MHz |
| reservedCode | output | 1 | The captured code is reserved or unassigned |
| powerDown | output | 1 | Live power-down request |

## Verification
The capture edge and the first power-down request can follow each other with no gap. The strobe goes high again right after the low pair that qualified the capture. The bench then checks that `powerDown` rises exactly three edges later and is never seen before `captured`. In a second case, the straps and the strobe change on the cycle right after the capture is accepted. The snapshot must keep the earlier values, which shows that the one-shot closes in the same cycle that it fires.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    FREQ_100 = 2'd0,
    FREQ_133 = 2'd1,
    FREQ_200 = 2'd2,
    FREQ_266 = 2'd3
  } cpuFreq_e;

  typedef struct packed {
    logic capture;
    logic isCaptured;
  } ctrlStrobe_t;

endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pwrStrobe,
  output strap_pkg::ctrlStrobe_t ctrlOut,
  output logic                   powerDown
);
  localparam int LOW_W = $clog2(QUAL_SAMPLES + 1);
  localparam logic [LOW_W-1:0] LOW_MAX  = LOW_W'(QUAL_SAMPLES);
  localparam logic [LOW_W-1:0] LOW_NEED = LOW_W'(QUAL_SAMPLES - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic [LOW_W-1:0]       lowCnt;
  logic                   capturedQ;
  logic                   captureNow;
  logic                   pdQ;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= 1'b1;
        else       syncChain <= pwrStrobe;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], pwrStrobe};
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lowCnt <= '0;
    else if (syncOut)      lowCnt <= '0;
    else if (lowCnt != LOW_MAX) lowCnt <= lowCnt + LOW_W'(1);
  end

  assign captureNow = !capturedQ && !syncOut && (lowCnt >= LOW_NEED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           capturedQ <= 1'b0;
    else if (captureNow) capturedQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdQ <= 1'b0;
    else       pdQ <= capturedQ & syncOut;
  end

  assign ctrlOut.capture    = captureNow;
  assign ctrlOut.isCaptured = capturedQ;
  assign powerDown          = pdQ;

  assert_capture_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    capturedQ |=> capturedQ);

  assert_pd_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !capturedQ |=> !pdQ);

  assert_capture_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capturedQ) |-> !pdQ);

endmodule

// File: rtl/strap_datapath.sv
module strap_datapath #(
  parameter int SEL_W  = 3,
  parameter int FREQ_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strap_pkg::ctrlStrobe_t ctrlIn,
  input  logic [SEL_W-1:0]       selBits,
  input  logic                   tableSel,
  output logic [SEL_W-1:0]       latchedSel,
  output logic                   latchedTable,
  output logic [FREQ_W-1:0]      cpuFreq,
  output logic                   reservedCode
);
  import strap_pkg::*;

  logic [SEL_W-1:0] selQ;
  logic             tableQ;
  cpuFreq_e         freqD;
  logic             resD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= '0;
      tableQ <= 1'b0;
    end else if (ctrlIn.capture) begin
      selQ   <= selBits;
      tableQ <= tableSel;
    end
  end

  always_comb begin
    freqD = FREQ_100;
    resD  = 1'b0;
    if (ctrlIn.isCaptured) begin
      if (tableQ) begin
        case (selQ[1:0])
          2'b00:   freqD = FREQ_100;
          2'b01:   freqD = FREQ_133;
          2'b10:   freqD = FREQ_200;
          default: resD  = 1'b1;
        endcase
      end else begin
        case (selQ[2:0])
          3'b101:  freqD = FREQ_100;
          3'b001:  freqD = FREQ_133;
          3'b010:  freqD = FREQ_200;
          3'b000:  freqD = FREQ_266;
          default: resD  = 1'b1;
        endcase
      end
    end
  end

  assign latchedSel   = selQ;
  assign latchedTable = tableQ;
  assign cpuFreq      = FREQ_W'(freqD);
  assign reservedCode = resD;

  assert_snapshot_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.isCaptured && !ctrlIn.capture) |=> ($stable(selQ) && $stable(tableQ)));

  assert_reserved_default_R7: assert property (@(posedge clk) disable iff (!rstN)
    resD |-> (freqD == FREQ_100));

  assert_idle_decode_R1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.isCaptured |-> (!resD && freqD == FREQ_100));

endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrStrobe,
  input  logic [2:0] selBits,
  input  logic       tableSel,
  output logic       captured,
  output logic [2:0] latchedSel,
  output logic       latchedTable,
  output logic [1:0] cpuFreq,
  output logic       reservedCode,
  output logic       powerDown
);
  strap_pkg::ctrlStrobe_t ctrlBus;

  strap_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_SAMPLES(QUAL_SAMPLES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pwrStrobe(pwrStrobe),
    .ctrlOut  (ctrlBus),
    .powerDown(powerDown)
  );

  strap_datapath #(
    .SEL_W (3),
    .FREQ_W(2)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlIn      (ctrlBus),
    .selBits     (selBits),
    .tableSel    (tableSel),
    .latchedSel  (latchedSel),
    .latchedTable(latchedTable),
    .cpuFreq     (cpuFreq),
    .reservedCode(reservedCode)
  );

  assign captured = ctrlBus.isCaptured;

endmodule

// File: tb/sim_strap_capture_top.sv
module sim_strap_capture_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrStrobe = 1'b1;
  logic [2:0] selBits = 3'b000;
  logic       tableSel = 1'b0;
  logic       captured, latchedTable, reservedCode, powerDown;
  logic [2:0] latchedSel;
  logic [1:0] cpuFreq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  strap_capture_top u0 (
    .clk(clk), .rstN(rstN), .pwrStrobe(pwrStrobe), .selBits(selBits),
    .tableSel(tableSel), .captured(captured), .latchedSel(latchedSel),
    .latchedTable(latchedTable), .cpuFreq(cpuFreq),
    .reservedCode(reservedCode), .powerDown(powerDown)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    pwrStrobe = 1'b1;
    edges(2);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive straps and strobe low; capture lands after the fourth edge.
  task automatic capture(input logic [2:0] s, input logic t);
    @(negedge clk);
    selBits = s;
    tableSel = t;
    pwrStrobe = 1'b0;
    edges(3);
    check("R2 not early", captured, 0);
    edges(1);
    check("R2 captured", captured, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    pwrStrobe = 1'b1;
    selBits = 3'b111;
    tableSel = 1'b1;
    edges(2);
    check("R1 captured", captured, 0);
    check("R1 latchedSel", latchedSel, 0);
    check("R1 latchedTable", latchedTable, 0);
    check("R1 cpuFreq", cpuFreq, 0);
    check("R1 reserved", reservedCode, 0);
    check("R1 powerDown", powerDown, 0);
    @(negedge clk);
    rstN = 1'b1;
    edges(3);
    check("R1 idle captured", captured, 0);
    check("R1 idle table", latchedTable, 0);
  endtask

  task automatic testDecode(input logic [2:0] s, input logic t,
                            input int expFreq, input int expRes, input string req);
    doReset();
    capture(s, t);
    check({req, " latchedSel"}, latchedSel, int'(s));
    check({req, " latchedTable"}, latchedTable, int'(t));
    check({req, " cpuFreq"}, cpuFreq, expFreq);
    check({req, " reserved"}, reservedCode, expRes);
  endtask

  task automatic testGlitch();
    doReset();
    @(negedge clk);
    selBits = 3'b010;
    pwrStrobe = 1'b0;
    @(negedge clk);
    pwrStrobe = 1'b1;
    edges(6);
    check("R3 glitch ignored", captured, 0);
    check("R9 pd before capture", powerDown, 0);
    check("R3 sel untouched", latchedSel, 0);
  endtask

  task automatic testOneShot();
    doReset();
    capture(3'b001, 1'b0);
    @(negedge clk);
    selBits = 3'b110;
    tableSel = 1'b1;
    pwrStrobe = 1'b1;
    edges(5);
    @(negedge clk);
    pwrStrobe = 1'b0;
    edges(6);
    check("R4 captured held", captured, 1);
    check("R4 latchedSel held", latchedSel, 1);
    check("R4 table held", latchedTable, 0);
    check("R4 cpuFreq held", cpuFreq, 1);
    check("R4 reserved held", reservedCode, 0);
  endtask

  task automatic testPowerDown();
    doReset();
    capture(3'b010, 1'b0);
    check("R8 pd low at capture", powerDown, 0);
    @(negedge clk);
    pwrStrobe = 1'b1;
    edges(2);
    check("R8 pd latency", powerDown, 0);
    edges(1);
    check("R8 pd asserted", powerDown, 1);
    @(negedge clk);
    pwrStrobe = 1'b0;
    edges(2);
    check("R8 pd still high", powerDown, 1);
    edges(1);
    check("R8 pd released", powerDown, 0);
    check("R4 freq kept", cpuFreq, 2);
  endtask

  task automatic testPdPreCapture();
    doReset();
    @(negedge clk);
    pwrStrobe = 1'b1;
    edges(5);
    check("R9 pd stays low", powerDown, 0);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testDecode(3'b101, 1'b0, 0, 0, "R5 101");
    testDecode(3'b001, 1'b0, 1, 0, "R5 001");
    testDecode(3'b010, 1'b0, 2, 0, "R5 010");
    testDecode(3'b000, 1'b0, 3, 0, "R5 000");
    testDecode(3'b111, 1'b0, 0, 1, "R7 111");
    testDecode(3'b011, 1'b0, 0, 1, "R7 011");
    testDecode(3'b100, 1'b0, 0, 1, "R7 100");
    testDecode(3'b110, 1'b0, 0, 1, "R7 110");
    testDecode(3'b000, 1'b1, 0, 0, "R6 00");
    testDecode(3'b101, 1'b1, 1, 0, "R6 C ignored 01");
    testDecode(3'b010, 1'b1, 2, 0, "R6 10");
    testDecode(3'b011, 1'b1, 0, 1, "R7 two-bit 11");
    testGlitch();
    testOneShot();
    testPowerDown();
    testPdPreCapture();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule